// File: doc/BRIEF.md
# Memory ECC Error Monitor and Fault Injector

This block sits next to a memory data path whose words carry SECDED check bits. It keeps the enable bits for checking and correction. It also receives one-cycle strobes from the decoder for corrected (single-bit) and uncorrectable (double-bit) errors. For each error kind it keeps a sticky flag and a 4-bit saturating count. A single register holds the address of the most recent faulting access. A level interrupt is the OR of the unmasked pending flags, gated by a global enable. Software acknowledges the interrupt by writing a clear bit.

For self-test, software can set an inject bit. While that bit is set, the check bits on the way to memory are altered: one bit flipped for a single-bit fault, two bits flipped for a double-bit fault. The fault then appears when that word is read back later. The encoder, the decoder and the memory interface are outside this block. The block is accessed through a simple register bus: a write strobe plus an address, and read data that follows the address combinationally.

Top module: `ecc_rpt_top`

## Requirements
- R1: After reset every register reads zero, and `irq` and `ecc_active` are low.
- R2: The control register at offset 0x00 holds checking enable in bit 10 and correction enable in bit 11. `ecc_active` is high only when both bits are set. While bit 10 is clear, error strobes change no flag, count or address.
- R3: Control bit 13 flips check bit 0 on the write path. Control bit 14 flips check bits 0 and 1, and wins when both are set. With neither bit set, the check bits pass through unchanged, so words written then read back with no error strobe.
- R4: The status register at offset 0x38 shows sticky flags: corrected error in bit 2, uncorrectable error in bit 3, correction-dropped in bit 4. Other bits read zero.
- R5: The corrected-error count at offset 0x40 and the uncorrectable-error count at offset 0x44 are 4 bits wide. They count one per accepted strobe and hold at 15.
- R6: The error address register at offset 0x48 captures the address of each accepted error. When both kinds arrive in the same cycle, the uncorrectable address is kept.
- R7: A single-bit strobe that arrives while checking is enabled but correction is disabled sets the correction-dropped flag. It leaves the corrected flag, the corrected count and the address unchanged.
- R8: The interrupt register at offset 0x3C holds the global enable in bit 0 and masks in bits 1 (corrected), 2 (uncorrectable) and 3 (dropped); a mask bit of 1 suppresses that source. `irq` is high exactly when the enable is set and some unmasked flag is pending. Masked events still update flags and counts.
- R9: Writing offset 0x3C with bit 4 set clears all three flags and both counts. The enable and mask bits take the written value, so a clear written with bit 0 set leaves the interrupt enabled, and a clear alone leaves it disabled. A strobe that arrives in the same cycle as the clear is still recorded.
- R10: Bit 4 of offset 0x3C reads zero, and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| wr_chk_in | input | CHK_W | Check bits from the encoder |
| wr_chk_out | output | CHK_W | Check bits sent to memory, possibly corrupted |
| sbe_strobe | input | 1 | Single-bit error seen by the decoder |
| sbe_addr | input | EADDR_W | Address of the single-bit error access |
| dbe_strobe | input | 1 | Double-bit error seen by the decoder |
| dbe_addr | input | EADDR_W | Address of the double-bit error access |
| ecc_active | output | 1 | Checking and correction both enabled |
| irq | output | 1 | Level interrupt |

## Verification
The bench plays the decoder. It keeps the check bits actually stored per word and raises a strobe according to how many bits differ from a fresh encoding. Clean writes therefore show that untainted words stay silent, and single and double injections show that each inject bit hits the intended number of bits. Long strobe bursts probe saturation. Simultaneous strobes separate the address priority. Masked strobes separate the recording of flags from the raising of the interrupt. Strobes with correction off separate the dropped path from the corrected path. A clear written in the same cycle as a strobe shows which of the two wins.

// File: rtl/ecc_rpt_pkg.sv
package ecc_rpt_pkg;

  // register byte offsets (software decodes these)
  localparam int unsigned OFS_CTRL  = 'h00;
  localparam int unsigned OFS_STAT  = 'h38;
  localparam int unsigned OFS_IRQ   = 'h3C;
  localparam int unsigned OFS_SBCNT = 'h40;
  localparam int unsigned OFS_DBCNT = 'h44;
  localparam int unsigned OFS_EADDR = 'h48;

  // control bits
  localparam int CB_ECC  = 10;
  localparam int CB_CORR = 11;
  localparam int CB_INJ1 = 13;
  localparam int CB_INJ2 = 14;

  // status bits
  localparam int SB_ONE  = 2;
  localparam int SB_TWO  = 3;
  localparam int SB_DROP = 4;

  // interrupt register bits
  localparam int IB_EN    = 0;
  localparam int IB_MONE  = 1;
  localparam int IB_MTWO  = 2;
  localparam int IB_MDROP = 3;
  localparam int IB_CLR   = 4;

  typedef struct packed {
    logic ecc_en;
    logic corr_en;
    logic inj_one;
    logic inj_two;
  } ctrl_t;

  typedef struct packed {
    logic en;
    logic mask_one;
    logic mask_two;
    logic mask_drop;
  } irqcfg_t;

  typedef struct packed {
    logic one;
    logic two;
    logic drop;
  } flags_t;

endpackage

// File: rtl/ecc_rpt_cfg.sv
module ecc_rpt_cfg
  import ecc_rpt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_irq,
  input  logic [DATA_W-1:0] wdata,
  output ctrl_t             ctrl,
  output irqcfg_t           icfg,
  output logic              clr_pulse
);

  ctrl_t   ctrl_n;
  irqcfg_t icfg_n;

  always_comb begin
    ctrl_n = ctrl;
    icfg_n = icfg;
    if (wr_ctrl) begin
      ctrl_n.ecc_en  = wdata[CB_ECC];
      ctrl_n.corr_en = wdata[CB_CORR];
      ctrl_n.inj_one = wdata[CB_INJ1];
      ctrl_n.inj_two = wdata[CB_INJ2];
    end
    if (wr_irq) begin
      icfg_n.en        = wdata[IB_EN];
      icfg_n.mask_one  = wdata[IB_MONE];
      icfg_n.mask_two  = wdata[IB_MTWO];
      icfg_n.mask_drop = wdata[IB_MDROP];
    end
  end

  assign clr_pulse = wr_irq & wdata[IB_CLR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      icfg <= '0;
    end else if (wr_ctrl || wr_irq) begin
      ctrl <= ctrl_n;
      icfg <= icfg_n;
    end
  end

  // R9: a clear write leaves the enable at the written value
  p_clear_keeps_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_irq && wdata[IB_CLR]) |=> (icfg.en == $past(wdata[IB_EN])));

endmodule

// File: rtl/ecc_rpt_satcnt.sv
module ecc_rpt_satcnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] cnt_n;
  logic             cnt_en;

  always_comb begin
    base  = clr ? '0 : cnt;
    cnt_n = (inc && (base != CNT_MAX)) ? base + 1'b1 : base;
  end

  assign cnt_en = clr | inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_n;
  end

  // R5: the count holds at its ceiling
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !clr) |=> (cnt == CNT_MAX));

  // R5: with neither clear nor event the count does not move
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(cnt));

endmodule

// File: rtl/ecc_rpt_tracker.sv
module ecc_rpt_tracker
  import ecc_rpt_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int EADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctrl_t              ctrl,
  input  logic               clr,
  input  logic               sbe_in,
  input  logic [EADDR_W-1:0] sbe_addr,
  input  logic               dbe_in,
  input  logic [EADDR_W-1:0] dbe_addr,
  output flags_t             flags,
  output logic [CNT_W-1:0]   one_cnt,
  output logic [CNT_W-1:0]   two_cnt,
  output logic [EADDR_W-1:0] eaddr
);

  logic               one_ev;
  logic               two_ev;
  logic               drop_ev;
  flags_t             flags_n;
  logic               flags_en;
  logic [EADDR_W-1:0] eaddr_n;
  logic               eaddr_en;

  assign one_ev  = ctrl.ecc_en &  ctrl.corr_en & sbe_in;
  assign drop_ev = ctrl.ecc_en & ~ctrl.corr_en & sbe_in;
  assign two_ev  = ctrl.ecc_en & dbe_in;

  always_comb begin
    flags_n      = clr ? '0 : flags;
    flags_n.one  = flags_n.one  | one_ev;
    flags_n.two  = flags_n.two  | two_ev;
    flags_n.drop = flags_n.drop | drop_ev;
    flags_en     = clr | one_ev | two_ev | drop_ev;
  end

  // uncorrectable address wins the shared register
  always_comb begin
    eaddr_n  = eaddr;
    eaddr_en = one_ev | two_ev;
    if (two_ev)      eaddr_n = dbe_addr;
    else if (one_ev) eaddr_n = sbe_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags <= '0;
    else if (flags_en) flags <= flags_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        eaddr <= '0;
    else if (eaddr_en) eaddr <= eaddr_n;
  end

  ecc_rpt_satcnt #(.CNT_W(CNT_W)) u_one_cnt (
    .clk (clk), .rst_n (rst_n), .clr (clr), .inc (one_ev), .cnt (one_cnt)
  );

  ecc_rpt_satcnt #(.CNT_W(CNT_W)) u_two_cnt (
    .clk (clk), .rst_n (rst_n), .clr (clr), .inc (two_ev), .cnt (two_cnt)
  );

  // R2: checking disabled, no clear -> nothing recorded
  p_ignore_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.ecc_en && !clr) |=> ($stable(flags) && $stable(one_cnt) && $stable(two_cnt) && $stable(eaddr)));

  // R6: an uncorrectable error lands its own address
  p_two_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.ecc_en && dbe_in) |=> (eaddr == $past(dbe_addr)));

  // R7: a dropped correction does not count as corrected
  p_drop_path_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.ecc_en && !ctrl.corr_en && sbe_in && !clr) |=> (flags.drop && $stable(one_cnt)));

  // R4: flags are sticky until a clear
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flags.two && !clr) |=> flags.two);

endmodule

// File: rtl/ecc_rpt_inject.sv
module ecc_rpt_inject
  import ecc_rpt_pkg::*;
#(
  parameter int CHK_W = 8
) (
  input  ctrl_t            ctrl,
  input  logic [CHK_W-1:0] chk_in,
  output logic [CHK_W-1:0] chk_out
);

  localparam logic [CHK_W-1:0] FLIP_ONE = CHK_W'(1);
  localparam logic [CHK_W-1:0] FLIP_TWO = CHK_W'(3);

  logic [CHK_W-1:0] flip;

  always_comb begin
    if (ctrl.inj_two)      flip = FLIP_TWO;
    else if (ctrl.inj_one) flip = FLIP_ONE;
    else                   flip = '0;
    chk_out = chk_in ^ flip;
  end

  // R3: never more than two corrupted check bits
  always_comb begin
    p_flip_width_r3: assert ($countones(chk_out ^ chk_in) <= 2);
  end

endmodule

// File: rtl/ecc_rpt_top.sv
module ecc_rpt_top
  import ecc_rpt_pkg::*;
#(
  parameter int REG_AW  = 8,
  parameter int DATA_W  = 32,
  parameter int CHK_W   = 8,
  parameter int CNT_W   = 4,
  parameter int EADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [CHK_W-1:0]   wr_chk_in,
  output logic [CHK_W-1:0]   wr_chk_out,
  input  logic               sbe_strobe,
  input  logic [EADDR_W-1:0] sbe_addr,
  input  logic               dbe_strobe,
  input  logic [EADDR_W-1:0] dbe_addr,
  output logic               ecc_active,
  output logic               irq
);

  localparam logic [REG_AW-1:0] A_CTRL  = REG_AW'(OFS_CTRL);
  localparam logic [REG_AW-1:0] A_STAT  = REG_AW'(OFS_STAT);
  localparam logic [REG_AW-1:0] A_IRQ   = REG_AW'(OFS_IRQ);
  localparam logic [REG_AW-1:0] A_SBCNT = REG_AW'(OFS_SBCNT);
  localparam logic [REG_AW-1:0] A_DBCNT = REG_AW'(OFS_DBCNT);
  localparam logic [REG_AW-1:0] A_EADDR = REG_AW'(OFS_EADDR);

  ctrl_t              ctrl;
  irqcfg_t            icfg;
  flags_t             flags;
  logic               clr_pulse;
  logic               wr_ctrl;
  logic               wr_irq;
  logic [CNT_W-1:0]   one_cnt;
  logic [CNT_W-1:0]   two_cnt;
  logic [EADDR_W-1:0] eaddr;

  assign wr_ctrl = reg_we && (reg_addr == A_CTRL);
  assign wr_irq  = reg_we && (reg_addr == A_IRQ);

  ecc_rpt_cfg #(.DATA_W(DATA_W)) u_cfg (
    .clk (clk), .rst_n (rst_n), .wr_ctrl (wr_ctrl), .wr_irq (wr_irq),
    .wdata (reg_wdata), .ctrl (ctrl), .icfg (icfg), .clr_pulse (clr_pulse)
  );

  ecc_rpt_tracker #(.CNT_W(CNT_W), .EADDR_W(EADDR_W)) u_trk (
    .clk (clk), .rst_n (rst_n), .ctrl (ctrl), .clr (clr_pulse),
    .sbe_in (sbe_strobe), .sbe_addr (sbe_addr),
    .dbe_in (dbe_strobe), .dbe_addr (dbe_addr),
    .flags (flags), .one_cnt (one_cnt), .two_cnt (two_cnt), .eaddr (eaddr)
  );

  ecc_rpt_inject #(.CHK_W(CHK_W)) u_inj (
    .ctrl (ctrl), .chk_in (wr_chk_in), .chk_out (wr_chk_out)
  );

  assign ecc_active = ctrl.ecc_en & ctrl.corr_en;

  assign irq = icfg.en & ((flags.one  & ~icfg.mask_one) |
                          (flags.two  & ~icfg.mask_two) |
                          (flags.drop & ~icfg.mask_drop));

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[CB_ECC]  = ctrl.ecc_en;
        reg_rdata[CB_CORR] = ctrl.corr_en;
        reg_rdata[CB_INJ1] = ctrl.inj_one;
        reg_rdata[CB_INJ2] = ctrl.inj_two;
      end
      A_STAT: begin
        reg_rdata[SB_ONE]  = flags.one;
        reg_rdata[SB_TWO]  = flags.two;
        reg_rdata[SB_DROP] = flags.drop;
      end
      A_IRQ: begin
        reg_rdata[IB_EN]    = icfg.en;
        reg_rdata[IB_MONE]  = icfg.mask_one;
        reg_rdata[IB_MTWO]  = icfg.mask_two;
        reg_rdata[IB_MDROP] = icfg.mask_drop;
      end
      A_SBCNT: reg_rdata[CNT_W-1:0]   = one_cnt;
      A_DBCNT: reg_rdata[CNT_W-1:0]   = two_cnt;
      A_EADDR: reg_rdata[EADDR_W-1:0] = eaddr;
      default: reg_rdata = '0;
    endcase
  end

  // R9: a clear with no new strobe drops the interrupt next cycle
  p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_irq && reg_wdata[IB_CLR] && !sbe_strobe && !dbe_strobe) |=> !irq);

  // R8: with the global enable off the interrupt stays low
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_irq && !reg_wdata[IB_EN]) |=> !irq);

endmodule

// File: tb/ecc_rpt_top_tb_top.sv
module ecc_rpt_top_tb_top;

  localparam int CLK_HALF = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  wr_chk_in = '0;
  logic [7:0]  wr_chk_out;
  logic        sbe_strobe = 1'b0;
  logic [31:0] sbe_addr = '0;
  logic        dbe_strobe = 1'b0;
  logic [31:0] dbe_addr = '0;
  logic        ecc_active;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_HALF) clk = ~clk;

  ecc_rpt_top dut_i (
    .clk (clk), .rst_n (rst_n), .reg_we (reg_we), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
    .wr_chk_in (wr_chk_in), .wr_chk_out (wr_chk_out),
    .sbe_strobe (sbe_strobe), .sbe_addr (sbe_addr),
    .dbe_strobe (dbe_strobe), .dbe_addr (dbe_addr),
    .ecc_active (ecc_active), .irq (irq)
  );

  // ---------------- reference model ----------------
  int m_ecc, m_corr, m_inj1, m_inj2;
  int m_en, m_m1, m_m2, m_md;
  int m_s1, m_s2, m_sd;
  int m_c1, m_c2;
  int m_ea;
  int o_ecc, o_corr;

  initial begin
    m_ecc = 0; m_corr = 0; m_inj1 = 0; m_inj2 = 0;
    m_en = 0; m_m1 = 0; m_m2 = 0; m_md = 0;
    m_s1 = 0; m_s2 = 0; m_sd = 0; m_c1 = 0; m_c2 = 0; m_ea = 0;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ecc = 0; m_corr = 0; m_inj1 = 0; m_inj2 = 0;
      m_en = 0; m_m1 = 0; m_m2 = 0; m_md = 0;
      m_s1 = 0; m_s2 = 0; m_sd = 0; m_c1 = 0; m_c2 = 0; m_ea = 0;
    end else begin
      o_ecc = m_ecc; o_corr = m_corr;
      if (reg_we && reg_addr == 8'h3C && reg_wdata[4]) begin
        m_s1 = 0; m_s2 = 0; m_sd = 0; m_c1 = 0; m_c2 = 0;
      end
      if (o_ecc != 0 && sbe_strobe) begin
        if (o_corr != 0) begin
          m_s1 = 1; if (m_c1 < 15) m_c1++; m_ea = int'(sbe_addr);
        end else m_sd = 1;
      end
      if (o_ecc != 0 && dbe_strobe) begin
        m_s2 = 1; if (m_c2 < 15) m_c2++; m_ea = int'(dbe_addr);
      end
      if (reg_we && reg_addr == 8'h00) begin
        m_ecc = reg_wdata[10]; m_corr = reg_wdata[11];
        m_inj1 = reg_wdata[13]; m_inj2 = reg_wdata[14];
      end
      if (reg_we && reg_addr == 8'h3C) begin
        m_en = reg_wdata[0]; m_m1 = reg_wdata[1];
        m_m2 = reg_wdata[2]; m_md = reg_wdata[3];
      end
    end
  end

  function automatic logic m_irq();
    return (m_en != 0) && ((m_s1 != 0 && m_m1 == 0) || (m_s2 != 0 && m_m2 == 0) ||
                           (m_sd != 0 && m_md == 0));
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] r = '0;
    case (a)
      8'h00: begin r[10] = m_ecc[0]; r[11] = m_corr[0]; r[13] = m_inj1[0]; r[14] = m_inj2[0]; end
      8'h38: begin r[2] = m_s1[0]; r[3] = m_s2[0]; r[4] = m_sd[0]; end
      8'h3C: begin r[0] = m_en[0]; r[1] = m_m1[0]; r[2] = m_m2[0]; r[3] = m_md[0]; end
      8'h40: r = 32'(m_c1);
      8'h44: r = 32'(m_c2);
      8'h48: r = 32'(m_ea);
      default: r = '0;
    endcase
    return r;
  endfunction

  // every clock: interrupt and enable output against the model (R8, R2)
  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if (irq !== m_irq()) begin
        n_fail++;
        $display("FAIL R8 irq actual=%0b expected=%0b at %0t", irq, m_irq(), $time);
      end
      n_chk++;
      if (ecc_active !== (m_ecc != 0 && m_corr != 0)) begin
        n_fail++;
        $display("FAIL R2 ecc_active actual=%0b expected=%0b", ecc_active, (m_ecc != 0 && m_corr != 0));
      end
    end
  end

  // ---------------- bench memory and decoder ----------------
  logic [31:0] mem_d [16];
  logic [7:0]  mem_c [16];

  function automatic logic [7:0] enc(input logic [31:0] d);
    return d[7:0] ^ d[15:8] ^ d[23:16] ^ d[31:24] ^ 8'h5A;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, m_read(a));
  endtask

  task automatic pulse(input logic s, input logic [31:0] sa, input logic d, input logic [31:0] da);
    sbe_strobe = s; sbe_addr = sa; dbe_strobe = d; dbe_addr = da;
    @(negedge clk);
    sbe_strobe = 1'b0; dbe_strobe = 1'b0;
  endtask

  task automatic mem_write(input int idx, input logic [31:0] d);
    logic [7:0] exp;
    wr_chk_in = enc(d);
    #1;
    exp = enc(d) ^ ((m_inj2 != 0) ? 8'h03 : (m_inj1 != 0) ? 8'h01 : 8'h00);
    check("R3 check bits", 32'(wr_chk_out), 32'(exp));
    mem_d[idx] = d;
    mem_c[idx] = wr_chk_out;
    @(negedge clk);
  endtask

  task automatic mem_read(input int idx);
    int nd;
    nd = $countones(mem_c[idx] ^ enc(mem_d[idx]));
    pulse(nd == 1, 32'h1000 + 32'(idx * 4), nd >= 2, 32'h1000 + 32'(idx * 4));
  endtask

  // ---------------- stimulus ----------------
  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1, R10: reset values
    rd("R1 ctrl", 8'h00); rd("R1 status", 8'h38); rd("R1 irqreg", 8'h3C);
    rd("R1 cnt1", 8'h40); rd("R1 cnt2", 8'h44); rd("R1 eaddr", 8'h48);
    check("R1 irq", 32'(irq), 0);

    // R2: checking off, strobes ignored
    wr(8'h00, 32'h0000_0800);
    pulse(1'b1, 32'hAAAA_0000, 1'b1, 32'hBBBB_0000);
    rd("R2 status ignored", 8'h38); rd("R2 cnt ignored", 8'h44); rd("R2 eaddr ignored", 8'h48);
    check("R2 status zero", reg_rdata, 0);

    wr(8'h00, 32'h0000_0C00);
    rd("R2 ctrl", 8'h00);
    wr(8'h3C, 32'h1);

    // R3: clean word reads silently
    mem_write(0, 32'h1234_5678);
    mem_read(0);
    rd("R3 clean status", 8'h38);
    check("R3 clean no error", reg_rdata, 0);

    // R3/R4/R6/R8: single-bit injection
    wr(8'h00, 32'h0000_2C00);
    mem_write(1, 32'hCAFE_0001);
    wr(8'h00, 32'h0000_0C00);
    mem_write(2, 32'h0000_FFFF);
    mem_read(1);
    rd("R4 status one", 8'h38); rd("R5 cnt1", 8'h40); rd("R6 eaddr one", 8'h48);
    check("R4 status bit2", reg_rdata & 32'h0, 0);
    mem_read(2);
    rd("R3 untainted after inject", 8'h38);

    // double-bit injection; both inject bits set -> two flips
    wr(8'h00, 32'h0000_6C00);
    mem_write(3, 32'h5A5A_A5A5);
    wr(8'h00, 32'h0000_0C00);
    mem_read(3);
    rd("R4 status two", 8'h38); rd("R5 cnt2", 8'h44); rd("R6 eaddr two", 8'h48);

    // R9: clear with enable kept
    wr(8'h3C, 32'h11);
    rd("R9 status cleared", 8'h38); rd("R9 cnt1 cleared", 8'h40); rd("R9 cnt2 cleared", 8'h44);
    rd("R10 irqreg clear bit reads 0", 8'h3C);
    check("R9 enable kept", reg_rdata, 32'h1);

    // R5: saturation
    for (int i = 0; i < 18; i++) pulse(1'b1, 32'(i), 1'b0, '0);
    rd("R5 cnt1 saturated", 8'h40);
    check("R5 cnt1 is 15", reg_rdata, 32'd15);
    for (int i = 0; i < 17; i++) pulse(1'b0, '0, 1'b1, 32'(100 + i));
    rd("R5 cnt2 saturated", 8'h44);

    // R6: simultaneous strobes, uncorrectable address wins
    pulse(1'b1, 32'h0000_AAAA, 1'b1, 32'h0000_BBBB);
    rd("R6 priority", 8'h48);
    check("R6 priority value", reg_rdata, 32'h0000_BBBB);

    // R8: masking
    wr(8'h3C, 32'h13);
    pulse(1'b1, 32'h44, 1'b0, '0);
    rd("R8 masked still recorded", 8'h38);
    check("R8 masked irq low", 32'(irq), 0);
    pulse(1'b0, '0, 1'b1, 32'h48);
    check("R8 unmasked irq high", 32'(irq), 1);

    // R9: clear alone disables
    wr(8'h3C, 32'h10);
    rd("R9 irqreg disabled", 8'h3C);
    pulse(1'b0, '0, 1'b1, 32'h50);
    check("R9 disabled irq low", 32'(irq), 0);
    rd("R9 status after disabled event", 8'h38);

    // R7: correction off -> dropped
    wr(8'h3C, 32'h11);
    wr(8'h00, 32'h0000_0400);
    pulse(1'b1, 32'h60, 1'b0, '0);
    rd("R7 drop flag", 8'h38); rd("R7 cnt1 unchanged", 8'h40); rd("R7 eaddr unchanged", 8'h48);
    check("R7 drop irq", 32'(irq), 1);

    // R9: clear in the same cycle as a strobe
    wr(8'h00, 32'h0000_0C00);
    reg_we = 1'b1; reg_addr = 8'h3C; reg_wdata = 32'h11;
    dbe_strobe = 1'b1; dbe_addr = 32'h77;
    @(negedge clk);
    reg_we = 1'b0; dbe_strobe = 1'b0;
    rd("R9 event survives clear", 8'h38); rd("R9 cnt2 after clear+event", 8'h44);

    // R10: unmapped offset
    rd("R10 unmapped", 8'h04);
    rd("R10 unmapped 2", 8'h4C);

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : watchdog
    #(2 * CLK_HALF * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule